// File: doc/BRIEF.md
# Depth-Cascaded FIFO Ring

This block builds one deep first-in, first-out buffer from a ring of identical storage slices. All slices share the write enable, the read enable, the reset and the data buses. At any moment only one slice owns writing and only one slice owns reading. The slice that owns writing stores each accepted word at its next location. When it stores into its last physical location, it sends a one-cycle hand-over strobe to the next slice in the ring, and that slice takes ownership from the following cycle. Read ownership moves in the same way, on a strobe of its own, when the last location of the owning slice is read. Keeping the two strobes apart means a write hand-over and a read hand-over in the same cycle, on different slices, cannot be mistaken for each other. One slice is strapped by parameter as the first-load slice. After reset it alone holds both ownerships.

The chip-level full flag is the OR of the per-slice full flags. The empty flag is built the same way from the per-slice empty flags. A slice reports full only while it owns writing, and empty only while it owns reading. In cascaded mode the total capacity is the slice depth times the slice count.

With `chain_en` low, the hand-over inputs are forced inactive and the block runs standalone. Only the first-load slice is used. It wraps on its own, a retransmit pulse rewinds its read position, and a half-full flag is produced. In cascaded mode both of these functions are disabled.

Top module: `depth_chain_fifo`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) leaves `empty`=1, `full`=0, `half_full`=0 and `rd_valid`=0. The slice numbered `FIRST_SLICE` then owns both writing and reading, and no other slice owns either.
- R2: In cascaded mode (`chain_en`=1), words come out in the order they were accepted, across slice boundaries and ring wraps. `full` rises after exactly `SLICE_DEPTH*SLICES` accepted writes with no reads.
- R3: A write presented while `full`=1 is discarded. It changes no flag and never appears on `rd_data`.
- R4: A read presented while `empty`=1 is discarded. `rd_valid` stays 0 on the following cycle.
- R5: An accepted read raises `rd_valid` and presents the word on `rd_data` on the cycle after the edge at which `rd_en` was sampled. Exactly one slice drives valid data.
- R6: A write into the last location of the write-owning slice passes write ownership to the next slice in the ring (index+1, wrapping to 0). Exactly one slice owns writing at any time.
- R7: A read from the last location of the read-owning slice passes read ownership onward in the same ring order. Exactly one slice owns reading at any time.
- R8: `full` and `empty` reflect the buffer state right after each edge, and they are never both 1.
- R9: In cascaded mode, `retx` has no effect and `half_full` stays 0.
- R10: In standalone mode (`chain_en`=0), capacity is `SLICE_DEPTH`. `half_full` is 1 exactly while more than `SLICE_DEPTH/2` words are held.
- R11: In standalone mode, a `retx` pulse sets the read position back to the first location and keeps the write position. Provided fewer than `SLICE_DEPTH` writes have occurred since reset, every word written since reset is then read again in order. Writes and reads presented in the same cycle as `retx` are discarded.
- R12: A write and a read accepted in the same cycle both take effect, even when they cross boundaries of different slices in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_en | input | 1 | 1 = cascaded ring, 0 = standalone first-load slice |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| retx | input | 1 | Retransmit request (standalone only) |
| rd_data | output | DATA_W | Word read, valid with rd_valid |
| rd_valid | output | 1 | rd_data holds a word read on the previous edge |
| full | output | 1 | Composite full flag |
| empty | output | 1 | Composite empty flag |
| half_full | output | 1 | More than half of one slice filled (standalone only) |

## Verification
The checks assume that `chain_en` changes only while `rst` is high. The bench switches mode only inside its reset task. The checks also assume that `retx` comes only in standalone mode, after fewer than `SLICE_DEPTH` writes since reset, when a rewind is meant to replay data. The bench obeys this in its one retransmit scenario; every other `retx` pulse it drives is in cascaded mode, where the pulse must be ignored. Boundary crossings are forced by a small configuration of three slices of depth four, with the first-load slice in the middle, swept through fills, drains, concurrent traffic and long pseudo-random runs.

// File: rtl/chain_pkg.sv
package chain_pkg;
  // Per-slice status bits gathered by the merge stage.
  typedef struct packed {
    logic full;
    logic empty;
    logic half;
    logic wtok;
    logic rtok;
  } slice_stat_t;
endpackage

// File: rtl/slice_ram.sv
module slice_ram #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import chain_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chained,
  input  logic          first_load,
  input  logic          xi_wr,
  input  logic          xi_rd,
  input  logic          wr_ok,
  input  logic          rd_ok,
  input  logic          retx_go,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          do_wr,
  output logic          do_rd,
  output logic          xo_wr,
  output logic          xo_rd,
  output logic          q_valid,
  output slice_stat_t   stat
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [CW-1:0] cnt;
  logic          wtok, rtok;
  logic          wr_last, rd_last;
  logic [AW-1:0] wptr_nxt, rptr_nxt;

  assign do_wr    = wr_ok & wtok;
  assign do_rd    = rd_ok & rtok;
  assign wr_last  = do_wr & (wptr == LAST);
  assign rd_last  = do_rd & (rptr == LAST);
  assign xo_wr    = wr_last & chained;
  assign xo_rd    = rd_last & chained;
  assign wptr_nxt = (wptr == LAST) ? '0 : wptr + 1'b1;
  assign rptr_nxt = (rptr == LAST) ? '0 : rptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      wtok    <= first_load;
      rtok    <= first_load;
      q_valid <= 1'b0;
    end else begin
      q_valid <= do_rd;
      if (retx_go) begin
        rptr <= '0;
        cnt  <= CW'(wptr);
      end else begin
        if (do_wr) wptr <= wptr_nxt;
        if (do_rd) rptr <= rptr_nxt;
        cnt <= cnt + CW'(do_wr) - CW'(do_rd);
      end
      if (chained) begin
        if (xi_wr)        wtok <= 1'b1;
        else if (wr_last) wtok <= 1'b0;
        if (xi_rd)        rtok <= 1'b1;
        else if (rd_last) rtok <= 1'b0;
      end
    end
  end

  always_comb begin
    stat.full  = wtok & (cnt == CW'(DEPTH));
    stat.empty = rtok & (cnt == '0);
    stat.half  = ~chained & (cnt > CW'(DEPTH / 2));
    stat.wtok  = wtok;
    stat.rtok  = rtok;
  end
endmodule

// File: rtl/chain_slice.sv
module chain_slice
  import chain_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chained,
  input  logic              first_load,
  input  logic              xi_wr,
  input  logic              xi_rd,
  input  logic              wr_ok,
  input  logic              rd_ok,
  input  logic              retx_go,
  input  logic [DATA_W-1:0] wr_data,
  output logic              xo_wr,
  output logic              xo_rd,
  output logic [DATA_W-1:0] q,
  output logic              q_valid,
  output slice_stat_t       stat
);
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  slice_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .chained(chained), .first_load(first_load),
    .xi_wr(xi_wr), .xi_rd(xi_rd), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .retx_go(retx_go), .wptr(wptr), .rptr(rptr), .do_wr(do_wr),
    .do_rd(do_rd), .xo_wr(xo_wr), .xo_rd(xo_rd), .q_valid(q_valid),
    .stat(stat)
  );

  slice_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(do_wr), .waddr(wptr), .wdata(wr_data),
    .re(do_rd), .raddr(rptr), .q(q)
  );
endmodule

// File: rtl/chain_merge.sv
module chain_merge
  import chain_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int SLICES = 3
) (
  input  slice_stat_t [SLICES-1:0]             stat_v,
  input  logic        [SLICES-1:0][DATA_W-1:0] q_v,
  input  logic        [SLICES-1:0]             qv_v,
  output logic                                 full,
  output logic                                 empty,
  output logic                                 half_full,
  output logic        [DATA_W-1:0]             rd_data,
  output logic                                 rd_valid
);
  always_comb begin
    full      = 1'b0;
    empty     = 1'b0;
    half_full = 1'b0;
    rd_data   = '0;
    rd_valid  = 1'b0;
    for (int i = 0; i < SLICES; i++) begin
      full      = full | stat_v[i].full;
      empty     = empty | stat_v[i].empty;
      half_full = half_full | stat_v[i].half;
      rd_valid  = rd_valid | qv_v[i];
      rd_data   = rd_data | (q_v[i] & {DATA_W{qv_v[i]}});
    end
  end
endmodule

// File: rtl/depth_chain_fifo.sv
module depth_chain_fifo
  import chain_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int SLICE_DEPTH = 4,
  parameter int SLICES      = 3,
  parameter int FIRST_SLICE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chain_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              retx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              full,
  output logic              empty,
  output logic              half_full
);
  slice_stat_t [SLICES-1:0]             stat_v;
  logic        [SLICES-1:0][DATA_W-1:0] q_v;
  logic        [SLICES-1:0]             qv_v;
  logic        [SLICES-1:0]             xo_wr_v, xo_rd_v;
  logic        [SLICES-1:0]             wtok_v, rtok_v;
  logic                                 retx_go, wr_ok, rd_ok;

  // Retransmit acts only standalone and blocks traffic in its cycle.
  assign retx_go = retx & ~chain_en;
  assign wr_ok   = wr_en & ~full & ~retx_go;
  assign rd_ok   = rd_en & ~empty & ~retx_go;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    localparam int PREV = (i == 0) ? SLICES - 1 : i - 1;
    logic xi_wr, xi_rd;
    assign xi_wr     = xo_wr_v[PREV] & chain_en;
    assign xi_rd     = xo_rd_v[PREV] & chain_en;
    assign wtok_v[i] = stat_v[i].wtok;
    assign rtok_v[i] = stat_v[i].rtok;

    chain_slice #(.DATA_W(DATA_W), .DEPTH(SLICE_DEPTH)) u_slice (
      .clk(clk), .rst(rst), .chained(chain_en),
      .first_load(i == FIRST_SLICE),
      .xi_wr(xi_wr), .xi_rd(xi_rd), .wr_ok(wr_ok), .rd_ok(rd_ok),
      .retx_go(retx_go), .wr_data(wr_data),
      .xo_wr(xo_wr_v[i]), .xo_rd(xo_rd_v[i]),
      .q(q_v[i]), .q_valid(qv_v[i]), .stat(stat_v[i])
    );
  end

  chain_merge #(.DATA_W(DATA_W), .SLICES(SLICES)) u_merge (
    .stat_v(stat_v), .q_v(q_v), .qv_v(qv_v),
    .full(full), .empty(empty), .half_full(half_full),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/chain_checker.sv
module chain_checker #(
  parameter int N     = 3,
  parameter int FIRST = 1
) (
  input logic         clk,
  input logic         rst,
  input logic         chain_en,
  input logic         wr_en,
  input logic         rd_en,
  input logic         retx,
  input logic         full,
  input logic         empty,
  input logic         half_full,
  input logic         rd_valid,
  input logic [N-1:0] wtok_v,
  input logic [N-1:0] rtok_v,
  input logic [N-1:0] xo_wr_v,
  input logic [N-1:0] qv_v
);
  localparam logic [N-1:0] FIRST_MASK = N'(1) << FIRST;

  AST_RESET_TOKENS: assert property (@(posedge clk)
    rst |=> (wtok_v == FIRST_MASK) && (rtok_v == FIRST_MASK)); // R1

  AST_ONE_WTOK: assert property (@(posedge clk) disable iff (rst)
    chain_en |-> $countones(wtok_v) == 1); // R6

  AST_ONE_RTOK: assert property (@(posedge clk) disable iff (rst)
    chain_en |-> $countones(rtok_v) == 1); // R7

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(qv_v)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !(retx && !chain_en)) |=> full); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> !rd_valid); // R4

  AST_HF_CHAINED: assert property (@(posedge clk) disable iff (rst)
    chain_en |-> !half_full); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R8

  if (N > 1) begin : g_move
    AST_WTOK_MOVES: assert property (@(posedge clk) disable iff (rst)
      (chain_en && (xo_wr_v != '0)) |=> wtok_v != $past(wtok_v)); // R6
  end
endmodule

bind depth_chain_fifo chain_checker #(.N(SLICES), .FIRST(FIRST_SLICE)) u_chk (
  .clk(clk), .rst(rst), .chain_en(chain_en), .wr_en(wr_en), .rd_en(rd_en),
  .retx(retx), .full(full), .empty(empty), .half_full(half_full),
  .rd_valid(rd_valid), .wtok_v(wtok_v), .rtok_v(rtok_v),
  .xo_wr_v(xo_wr_v), .qv_v(qv_v)
);

// File: tb/sim_depth_chain_fifo.sv
module sim_depth_chain_fifo;
  localparam int W = 9;
  localparam int D = 4;
  localparam int N = 3;
  localparam int F = 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         chain_en = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0, retx = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid, full, empty, half_full;

  int checks = 0;
  int fails  = 0;
  int q[$];
  int hist[$];
  int cap;
  int nextv = 1;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  depth_chain_fifo #(.DATA_W(W), .SLICE_DEPTH(D), .SLICES(N), .FIRST_SLICE(F)) u0 (
    .clk(clk), .rst(rst), .chain_en(chain_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .retx(retx), .rd_data(rd_data), .rd_valid(rd_valid),
    .full(full), .empty(empty), .half_full(half_full)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_flags();
    chk(full == (q.size() == cap), "R8", "full", int'(full), int'(q.size() == cap));
    chk(empty == (q.size() == 0), "R8", "empty", int'(empty), int'(q.size() == 0));
    if (chain_en)
      chk(half_full == 1'b0, "R9", "half_full chained", int'(half_full), 0);
    else
      chk(half_full == (q.size() > D / 2), "R10", "half_full", int'(half_full),
          int'(q.size() > D / 2));
  endtask

  task automatic do_reset(input bit chained);
    @(negedge clk);
    rst = 1'b1; chain_en = chained; wr_en = 0; rd_en = 0; retx = 0;
    @(posedge clk); @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
    q.delete(); hist.delete();
    cap = chained ? D * N : D;
    #1;
    chk(full == 1'b0, "R1", "full after reset", int'(full), 0);
    chk(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);
    chk(half_full == 1'b0, "R1", "half_full after reset", int'(half_full), 0);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
  endtask

  // One clock: inputs driven at the falling edge, results sampled after the rising edge.
  task automatic cyc(input bit w, input bit r, input bit x, input string tag);
    bit rx, wacc, racc;
    int expv;
    @(negedge clk);
    wr_en = w; rd_en = r; retx = x; wr_data = W'(nextv);
    rx   = x && !chain_en;
    wacc = w && (q.size() != cap) && !rx;
    racc = r && (q.size() != 0) && !rx;
    @(posedge clk); #1;
    expv = 0;
    if (rx) q = hist;
    if (racc) expv = q.pop_front();
    if (wacc) begin
      q.push_back(nextv % (1 << W));
      hist.push_back(nextv % (1 << W));
    end
    if (w) nextv++;
    chk(rd_valid == racc, (r && !racc) ? "R4" : "R5", "rd_valid", int'(rd_valid), int'(racc));
    if (racc) chk(int'(rd_data) == expv, tag, "rd_data", int'(rd_data), expv);
    check_flags();
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state in cascaded mode
    do_reset(1'b1);

    // R2: fill to capacity across all slices, starting at the middle slice
    for (int i = 0; i < D * N; i++) cyc(1, 0, 0, "R2");
    chk(full == 1'b1, "R2", "full after capacity writes", int'(full), 1);
    // R3: writes while full are discarded
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R3");
    // R7: drain crosses every read hand-over; values prove R3 discards
    for (int i = 0; i < D * N; i++) cyc(0, 1, 0, "R7");
    // R4: reads while empty are discarded
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R4");
    cyc(1, 0, 0, "R4");
    cyc(0, 1, 0, "R4");

    // R12: concurrent write and read through many boundaries
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, "R12");
    for (int i = 0; i < 60; i++) cyc(1, 1, 0, "R12");
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, "R12");

    // R6: pseudo-random traffic, several ring wraps
    for (int i = 0; i < 1200; i++) begin
      int unsigned v = rnd();
      cyc(v[0] | v[3], v[1] | v[4], 1'b0, "R6");
    end
    // R9: retransmit pulses in cascaded mode must change nothing
    for (int i = 0; i < 200; i++) begin
      int unsigned v = rnd();
      cyc(v[0], v[1], v[2], "R9");
    end
    for (int i = 0; i < D * N + 2; i++) cyc(0, 1, 0, "R2");

    // R10: standalone capacity and half-full
    do_reset(1'b0);
    for (int i = 0; i < D + 2; i++) cyc(1, 0, 0, "R10");
    chk(full == 1'b1, "R10", "standalone full", int'(full), 1);
    for (int i = 0; i < D + 1; i++) cyc(0, 1, 0, "R10");

    // R11: rewind replays everything written since reset
    do_reset(1'b0);
    for (int i = 0; i < D - 1; i++) cyc(1, 0, 0, "R11");
    cyc(0, 1, 0, "R11");
    cyc(0, 1, 0, "R11");
    cyc(1, 1, 1, "R11");
    chk(empty == 1'b0, "R11", "not empty after rewind", int'(empty), 0);
    for (int i = 0; i < D; i++) cyc(0, 1, 0, "R11");

    // R10: random standalone traffic with pointer wraps
    do_reset(1'b0);
    for (int i = 0; i < 600; i++) begin
      int unsigned v = rnd();
      cyc(v[0], v[1], 1'b0, "R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule